// File: doc/BRIEF.md
# Host Frame Interval Timer

This block paces a host controller's frames. A down-counter in the PHY clock domain loads a frame interval, counts down by one each PHY cycle and, when it reaches zero, reloads and raises a one-cycle start-of-frame strobe. An 11-bit frame number advances with every strobe.

Software sets the interval through a write port in a separate register clock domain. It may change the interval at any time to trim the frame period, for example to track an external device. Each written value crosses into the PHY domain through a toggle handshake and lands in a pending register. The counter reads that register only when it reloads, so the frame in progress always keeps the length it started with.

The write port follows valid/ready rules. A value is taken on a register-clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` then stays low until the PHY side has captured the value and its acknowledgement has come back. While `wr_ready` is low the source holds `wr_valid` and `wr_interval` steady. The frame timer has no back-pressure path. The enable input pauses the timer and restarts it with a whole frame.

Top module: `fi_host_sof_timer`

## Requirements
- R1: While enabled, the counter falls by one each PHY cycle. Consecutive strobes on `sof_o` are therefore exactly N+1 PHY cycles apart, where N is the interval loaded at the earlier reload.
- R2: `sof_o` is high for exactly one PHY cycle at each reload. In the same cycle the counter is reloaded from the pending interval.
- R3: A write accepted during a frame leaves that frame's length unchanged. The new interval is used from the first reload after the handshake completes. For example, 400 followed by a mid-frame write of 450 gives a 401-cycle frame and then 451-cycle frames.
- R4: If several writes complete within one frame, the next reload uses the last of them.
- R5: `frame_num` is 11 bits wide. It rises by one in the same cycle that `sof_o` goes high and wraps from 2047 to 0.
- R6: While `tmr_en` is low, no strobe appears, `frame_num` holds its value and the counter tracks the pending interval.
- R7: After `tmr_en` rises, the first strobe appears after a whole frame of N+1 PHY cycles, where N is the latest pending interval, including a value written while the timer was disabled.
- R8: `wr_ready` goes low in the cycle after a value is accepted. It returns high once the value has been captured in the PHY domain, and the held value does not change while the handshake is open.
- R9: After reset, the interval is the `RST_IVL` parameter, `frame_num` is 0, `sof_o` is low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Register write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_valid | input | 1 | Interval write request |
| wr_ready | output | 1 | Write port can accept a value |
| wr_interval | input | IVL_W | Frame interval value N (frame = N+1 PHY cycles) |
| phy_clk | input | 1 | PHY clock that times frames |
| phy_rst_n | input | 1 | Asynchronous active-low reset, PHY domain |
| tmr_en | input | 1 | Timer run enable |
| sof_o | output | 1 | One-cycle start-of-frame strobe |
| frame_num | output | FNUM_W | Frame number, advances at each strobe |

## Verification
The assertions check the following on every PHY cycle:
- the count falls one step at a time;
- each zero triggers a reload together with a strobe;
- the active interval stays fixed within a frame;
- the frame number steps on each strobe;
- no strobe appears while disabled.

On the write side, the assertions check that the held value stays steady while the handshake is open.

Some behaviour spans both clock domains or many frames, so only the bench scenarios can show it:
- a mid-frame change takes effect at the following frame (the 400 to 450 case);
- the last of several writes wins;
- re-enabling after a write made while disabled starts a frame of the new length;
- the frame number wraps after 2048 frames.

// File: rtl/fi_pkg.sv
package fi_pkg;

  localparam int SYNC_STAGES_DEF = 2;

  typedef enum logic {
    TMR_HOLD = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/fi_bit_sync.sv
module fi_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/fi_wr_port.sv
module fi_wr_port #(
  parameter int IVL_W   = 16,
  parameter int RST_IVL = 47999,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [IVL_W-1:0] data_i,
  output logic             ready_o,
  output logic [IVL_W-1:0] hold_o,
  output logic             req_tgl_o,
  input  logic             ack_tgl_i
);

  logic             busy_q;
  logic             req_q;
  logic [IVL_W-1:0] hold_q;
  logic             ack_s;
  logic             accept;

  fi_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ack_tgl_i),
    .q_o  (ack_s)
  );

  assign accept = valid_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= IVL_W'(RST_IVL);
    end else if (accept) begin
      hold_q <= data_i;
      req_q  <= ~req_q;
      busy_q <= 1'b1;
    end else if (busy_q && (ack_s == req_q)) begin
      busy_q <= 1'b0;
    end
  end

  assign ready_o   = !busy_q;
  assign hold_o    = hold_q;
  assign req_tgl_o = req_q;

  // R8: value held steady while the handshake is open
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (ack_s != req_q)) |=> $stable(hold_q));

  // R8: port closes after an accepted write
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o);

endmodule

// File: rtl/fi_ivl_capture.sv
module fi_ivl_capture #(
  parameter int IVL_W   = 16,
  parameter int RST_IVL = 47999,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl_i,
  input  logic [IVL_W-1:0] hold_i,
  output logic [IVL_W-1:0] pend_o,
  output logic             ack_tgl_o
);

  logic             req_s;
  logic             seen_q;
  logic [IVL_W-1:0] pend_q;
  logic             fresh;

  fi_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (req_tgl_i),
    .q_o  (req_s)
  );

  assign fresh = req_s ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pend_q <= IVL_W'(RST_IVL);
    end else if (fresh) begin
      seen_q <= req_s;
      pend_q <= hold_i;
    end
  end

  assign pend_o    = pend_q;
  assign ack_tgl_o = seen_q;

  // R4: pending changes only on a fresh handshake
  p_pend_only_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s == seen_q) |=> $stable(pend_q));

endmodule

// File: rtl/fi_frame_timer.sv
module fi_frame_timer
  import fi_pkg::*;
#(
  parameter int IVL_W   = 16,
  parameter int FNUM_W  = 11,
  parameter int RST_IVL = 47999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [IVL_W-1:0]  pend_i,
  output logic              sof_o,
  output logic [FNUM_W-1:0] fnum_o
);

  tmr_state_e        st_q;
  logic [IVL_W-1:0]  cnt_q;
  logic [IVL_W-1:0]  act_q;
  logic              sof_q;
  logic [FNUM_W-1:0] fnum_q;
  logic              at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TMR_HOLD;
      cnt_q  <= IVL_W'(RST_IVL);
      act_q  <= IVL_W'(RST_IVL);
      sof_q  <= 1'b0;
      fnum_q <= '0;
    end else begin
      sof_q <= 1'b0;
      if (!en_i) begin
        st_q  <= TMR_HOLD;
        cnt_q <= pend_i;
        act_q <= pend_i;
      end else begin
        st_q <= TMR_RUN;
        if (at_zero) begin
          cnt_q  <= pend_i;
          act_q  <= pend_i;
          sof_q  <= 1'b1;
          fnum_q <= fnum_q + 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign sof_o  = sof_q;
  assign fnum_o = fnum_q;

  // R1: one step down per enabled cycle
  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: zero reloads with a strobe
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && at_zero) |=> (sof_q && (cnt_q == act_q)));

  // R2: strobe lasts one cycle when interval is nonzero
  p_sof_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_q && (act_q != '0)) |=> !sof_q);

  // R3: the running frame keeps its interval
  p_frame_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !at_zero) |=> $stable(act_q));

  // R5: frame number steps with each strobe
  p_fnum_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> (fnum_q == FNUM_W'($past(fnum_q) + 1'b1)));

  // R6: quiet while disabled
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!sof_q && $stable(fnum_q)));

  // R6: held state never shows a strobe
  p_hold_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TMR_HOLD) |-> !sof_q);

endmodule

// File: rtl/fi_host_sof_timer.sv
module fi_host_sof_timer
  import fi_pkg::*;
#(
  parameter int IVL_W       = 16,
  parameter int FNUM_W      = 11,
  parameter int RST_IVL     = 47999,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IVL_W-1:0]  wr_interval,
  input  logic              phy_clk,
  input  logic              phy_rst_n,
  input  logic              tmr_en,
  output logic              sof_o,
  output logic [FNUM_W-1:0] frame_num
);

  logic [IVL_W-1:0] hold_w;
  logic [IVL_W-1:0] pend_w;
  logic             req_tgl;
  logic             ack_tgl;

  fi_wr_port #(
    .IVL_W  (IVL_W),
    .RST_IVL(RST_IVL),
    .STAGES (SYNC_STAGES)
  ) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .valid_i  (wr_valid),
    .data_i   (wr_interval),
    .ready_o  (wr_ready),
    .hold_o   (hold_w),
    .req_tgl_o(req_tgl),
    .ack_tgl_i(ack_tgl)
  );

  fi_ivl_capture #(
    .IVL_W  (IVL_W),
    .RST_IVL(RST_IVL),
    .STAGES (SYNC_STAGES)
  ) u_cap (
    .clk      (phy_clk),
    .rst_n    (phy_rst_n),
    .req_tgl_i(req_tgl),
    .hold_i   (hold_w),
    .pend_o   (pend_w),
    .ack_tgl_o(ack_tgl)
  );

  fi_frame_timer #(
    .IVL_W  (IVL_W),
    .FNUM_W (FNUM_W),
    .RST_IVL(RST_IVL)
  ) u_tmr (
    .clk   (phy_clk),
    .rst_n (phy_rst_n),
    .en_i  (tmr_en),
    .pend_i(pend_w),
    .sof_o (sof_o),
    .fnum_o(frame_num)
  );

endmodule

// File: tb/fi_host_sof_timer_tb.sv
module fi_host_sof_timer_tb;

  localparam int IVL_W   = 16;
  localparam int FNUM_W  = 11;
  localparam int RST_IVL = 60;

  logic              wr_clk = 1'b0;
  logic              phy_clk = 1'b0;
  logic              wr_rst_n = 1'b0;
  logic              phy_rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [IVL_W-1:0]  wr_interval = '0;
  logic              tmr_en = 1'b0;
  logic              wr_ready;
  logic              sof_o;
  logic [FNUM_W-1:0] frame_num;

  int n_chk = 0;
  int n_err = 0;
  int exp_fn = 0;
  bit wrap_seen = 1'b0;
  bit prev_sof = 1'b0;

  always #2 wr_clk = ~wr_clk;
  always #3 phy_clk = ~phy_clk;

  fi_host_sof_timer #(
    .IVL_W  (IVL_W),
    .FNUM_W (FNUM_W),
    .RST_IVL(RST_IVL)
  ) u_dut (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_interval(wr_interval),
    .phy_clk    (phy_clk),
    .phy_rst_n  (phy_rst_n),
    .tmr_en     (tmr_en),
    .sof_o      (sof_o),
    .frame_num  (frame_num)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input int ivl);
    return ivl + 1;
  endfunction

  function automatic int fn_next(input int fn);
    return (fn + 1) % (1 << FNUM_W);
  endfunction

  // R2 and R5 monitor: one-cycle strobe, frame number step and wrap
  always @(negedge phy_clk) begin
    if (phy_rst_n) begin
      if (sof_o) begin
        exp_fn = fn_next(exp_fn);
        if (exp_fn == 0) wrap_seen = 1'b1;
        chk(frame_num == FNUM_W'(exp_fn), "R5 frame number", int'(frame_num), exp_fn);
        chk(!prev_sof, "R2 strobe width", int'(prev_sof), 0);
      end
      prev_sof = sof_o;
    end
  end

  task automatic wr(input int v);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_interval = IVL_W'(v);
    while (!wr_ready) @(negedge wr_clk);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    chk(!wr_ready, "R8 ready low after accept", int'(wr_ready), 0);
    while (!wr_ready) @(negedge wr_clk);
  endtask

  task automatic next_sof(output int n);
    n = 0;
    do begin
      @(negedge phy_clk);
      n++;
    end while (!sof_o);
  endtask

  initial begin
    #600000;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    int prev;
    int v;
    int fn_hold;
    int sof_cnt;
    void'($urandom(32'd2718));

    repeat (4) @(negedge phy_clk);
    wr_rst_n = 1'b1;
    phy_rst_n = 1'b1;
    @(negedge phy_clk);
    // R9 reset state
    chk(!sof_o, "R9 sof after reset", int'(sof_o), 0);
    chk(frame_num == '0, "R9 frame number after reset", int'(frame_num), 0);
    chk(wr_ready, "R9 ready after reset", int'(wr_ready), 1);

    // R7 / R9: first frame after enable uses reset interval
    tmr_en = 1'b1;
    next_sof(n);
    chk(n == frame_len(RST_IVL), "R7 first frame after enable", n, frame_len(RST_IVL));
    next_sof(n);
    chk(n == frame_len(RST_IVL), "R1 steady period", n, frame_len(RST_IVL));

    // R3: 400 then mid-frame 450
    wr(400);
    next_sof(n);
    next_sof(n);
    chk(n == frame_len(400), "R1 period 400", n, frame_len(400));
    fork
      wr(450);
      next_sof(n);
    join
    chk(n == frame_len(400), "R3 current frame untouched", n, frame_len(400));
    next_sof(n);
    chk(n == frame_len(450), "R3 next frame uses new value", n, frame_len(450));

    // R4: several writes in one frame, last one wins
    fork
      begin
        wr(100);
        wr(37);
        wr(75);
      end
      next_sof(n);
    join
    chk(n == frame_len(450), "R4 current frame untouched", n, frame_len(450));
    next_sof(n);
    chk(n == frame_len(75), "R4 last write applied", n, frame_len(75));

    // R1 / R3: random intervals
    prev = 75;
    for (int i = 0; i < 8; i++) begin
      v = $urandom_range(120, 20);
      fork
        wr(v);
        next_sof(n);
      join
      chk(n == frame_len(prev), "R3 random current frame", n, frame_len(prev));
      next_sof(n);
      chk(n == frame_len(v), "R1 random new period", n, frame_len(v));
      prev = v;
    end

    // R6: disable, no strobe, frame number held
    @(negedge phy_clk);
    tmr_en = 1'b0;
    fn_hold = int'(frame_num);
    sof_cnt = 0;
    fork
      wr(33);
      for (int i = 0; i < 60; i++) begin
        @(negedge phy_clk);
        if (sof_o) sof_cnt++;
      end
    join
    chk(sof_cnt == 0, "R6 no strobe while disabled", sof_cnt, 0);
    chk(int'(frame_num) == fn_hold, "R6 frame number held", int'(frame_num), fn_hold);

    // R7: re-enable starts a full frame of latest interval
    tmr_en = 1'b1;
    next_sof(n);
    chk(n == frame_len(33), "R7 full frame after re-enable", n, frame_len(33));

    // R5: wrap with a short interval
    wr(3);
    next_sof(n);
    next_sof(n);
    chk(n == frame_len(3), "R1 short period", n, frame_len(3));
    wrap_seen = 1'b0;
    for (int i = 0; i < 2100 && !wrap_seen; i++) next_sof(n);
    chk(wrap_seen, "R5 wrap to zero", int'(wrap_seen), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule